// File: doc/BRIEF.md
# System Clock Source Selector and Prescaler

This block picks one of three clock sources and divides it down to form the system clock: an internal ring oscillator, a fast main oscillator or a slow sub oscillator. From the system clock it then derives an instruction clock at one third of that rate, and a machine-cycle strobe. A 4-bit mode register on a configuration clock holds the source choice and the divide choice, and it can be read back at any time. Reset forces the ring oscillator divided by eight.

A source change is glitch-free. Each source owns a small enable shifter clocked on its own falling edge. The new source is only enabled after the old one has dropped out, and after two of the new source's own falling edges. A change of divide ratio is taken up by the prescaler only when its count wraps, so the period in progress always completes. The system clock is the selected source gated by an enable that changes only while that source is low. Every high pulse is therefore half a source period wide, and the system clock repeats once every N source cycles.

Top module: `sysclk_gen`

## Requirements
- R1: After reset the mode register reads 4'b0011: source field (bits 3:2) = 00, divide field (bits 1:0) = 11.
- R2: After reset the system clock is the ring oscillator divided by 8.
- R3: The divide field sets the ratio applied to the chosen source: 11 gives /8, 10 gives /4, 01 gives /2 and 00 gives /1 (the source passes through).
- R4: The source field selects the source: 00 selects the ring oscillator, 01 the fast oscillator and 10 the slow oscillator.
- R5: A write whose source field is 11 leaves the source field unchanged and still loads the divide field.
- R6: A source switch never puts on the system clock a high or low phase shorter than the shortest half period of the sources involved. At most one source is enabled at any time.
- R7: A new divide ratio takes effect only at the end of the output period in progress. No system clock period during the change is shorter than the shorter of the old and new periods.
- R8: The instruction clock has a period of exactly three system clock periods.
- R9: The machine-cycle strobe is high for exactly one system clock cycle in every three. After reset is released it first rises on the second system clock rising edge.
- R10: A read returns the last accepted mode value. A write lands one configuration clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock for the mode register |
| rst_n | input | 1 | Synchronous active-low reset, seen by every clock domain |
| clk_ring | input | 1 | Internal ring oscillator clock |
| clk_high | input | 1 | Fast main oscillator clock |
| clk_low | input | 1 | Slow sub oscillator clock |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 4 | Mode value to write: [3:2] source, [1:0] divide |
| rd_data | output | 4 | Current mode register value |
| sys_clk | output | 1 | System clock |
| instr_clk | output | 1 | Instruction clock, system clock divided by three |
| mc_strobe | output | 1 | One-cycle machine-cycle strobe in the system clock domain |

## Verification
The assertions assume that reset is held low long enough for every source clock, and the system clock derived from the ring, to see it on several edges. This is because each domain resets synchronously. They also assume that every source keeps toggling while it is selected or being switched away from. Otherwise an enable shifter could never clear. The bench holds reset for two microseconds, keeps all three oscillators running throughout, and gives each mode change a settling window longer than the slowest resulting period before it measures anything.

// File: rtl/sysclk_pkg.sv
// Shared types for the system clock generator.
// Assumes: mode register layout is [3:2] source, [1:0] divide code.
package sysclk_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_W   = 2;
    localparam int DIV_W   = 2;
    localparam int MODE_W  = SRC_W + DIV_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_RING = 2'b00,
        SRC_HIGH = 2'b01,
        SRC_LOW  = 2'b10,
        SRC_BAD  = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e           src;
        logic [DIV_W-1:0]   div;
    } mode_t;

    localparam mode_t MODE_RESET = '{src: SRC_RING, div: 2'b11};
endpackage

// File: rtl/sysclk_mode_reg.sv
// Mode register in the configuration clock domain.
// Holds the source and divide fields. A write naming source 11 keeps the old
// source but still loads the divide field. Assumes a synchronous active-low reset.
module sysclk_mode_reg
    import sysclk_pkg::*;
(
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output mode_t             mode
);
    mode_t mode_q;
    mode_t wr_mode;

    // Split the incoming write into its fields.
    always_comb wr_mode = mode_t'(wr_data);

    // Load the register; an illegal source code leaves the source untouched.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (wr_en) begin
            mode_q.div <= wr_mode.div;
            if (wr_mode.src != SRC_BAD) begin
                mode_q.src <= wr_mode.src;
            end
        end
    end

    assign mode = mode_q;

    assert_src_legal_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        mode_q.src != SRC_BAD);
    assert_keep_src_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_W-1 -: SRC_W] == 2'b11) |=> $stable(mode_q.src));
    assert_div_take_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        wr_en |=> (mode_q.div == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/sysclk_src_mux.sv
// Glitch-free source selector.
// Each source has an enable shifter clocked on its own falling edge. A source
// asks for enable only when it is selected and no other source is enabled, so
// the old source drops before the new one rises. Assumes all sources keep
// running and reset is held over several edges of each.
module sysclk_src_mux
    import sysclk_pkg::*;
#(
    parameter int N_SRC       = NUM_SRC,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_SRC   = 0
) (
    input  logic             cfg_clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] clk_src,
    input  logic [SRC_W-1:0] sel,
    output logic             clk_out
);
    logic [N_SRC-1:0] en;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [SYNC_STAGES-1:0] chain;
        logic                   want;

        // Request enable when selected and every other source is idle.
        always_comb want = (sel == SRC_W'(i)) &&
                           ((en & ~(N_SRC'(1) << i)) == '0);

        // Shift the request through stages clocked by this source's falling edge.
        always_ff @(negedge clk_src[i]) begin
            if (!rst_n) begin
                chain <= {SYNC_STAGES{(i == RESET_SRC)}};
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], want};
            end
        end

        assign en[i] = chain[SYNC_STAGES-1];
    end

    // Enables change only while their source is low, so the OR is clean.
    assign clk_out = |(clk_src & en);

    assert_one_source_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(en));
endmodule

// File: rtl/sysclk_prescaler.sv
// Power-of-two prescaler by clock gating.
// Counts down on the muxed clock and opens the gate for one cycle when the count
// is zero. The divide code is synchronised in, and it is sampled only when the count
// wraps, so a period in progress always finishes. Assumes the gate flop is
// updated while the clock is low.
module sysclk_prescaler
    import sysclk_pkg::*;
#(
    parameter int CODE_W      = DIV_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              sys_clk
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] div_sync [SYNC_STAGES];
    logic [CODE_W-1:0] div_q;
    logic [CNT_W:0]    span;
    logic [CNT_W-1:0]  reload;
    logic [CNT_W-1:0]  cnt;
    logic              gate;

    // Bring the divide code into the muxed clock domain.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) div_sync[s] <= '1;
        end else begin
            div_sync[0] <= div_code;
            for (int s = 1; s < SYNC_STAGES; s++) div_sync[s] <= div_sync[s-1];
        end
    end

    assign div_q = div_sync[SYNC_STAGES-1];

    // Reload value is the ratio minus one.
    always_comb begin
        span   = (CNT_W+1)'(1) << div_q;
        reload = CNT_W'(span - 1'b1);
    end

    // Down counter; the ratio is picked up only on the wrap.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Gate enable, changed on the falling edge so the output cannot glitch.
    always_ff @(negedge mclk) begin
        if (!rst_n) begin
            gate <= 1'b1;
        end else begin
            gate <= (cnt == '0);
        end
    end

    assign sys_clk = mclk & gate;

    assert_count_down_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    assert_gate_on_wrap_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        gate |-> (cnt == '0));
endmodule

// File: rtl/sysclk_div3.sv
// Divide-by-three for the instruction clock and machine-cycle strobe.
// Phase counter runs on the system clock. The strobe marks the last phase and the
// instruction clock is high during phase zero. Assumes synchronous active-low reset.
module sysclk_div3 #(
    parameter int DIV_FACTOR = 3
) (
    input  logic sys_clk,
    input  logic rst_n,
    output logic instr_clk,
    output logic mc_strobe
);
    localparam int PH_W = $clog2(DIV_FACTOR);
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV_FACTOR - 1);

    logic [PH_W-1:0] ph;
    logic            instr_q;

    // Step the phase and register the instruction clock level.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            ph      <= '0;
            instr_q <= 1'b1;
        end else begin
            ph      <= (ph == LAST) ? '0 : ph + 1'b1;
            instr_q <= (ph == LAST);
        end
    end

    assign instr_clk = instr_q;
    assign mc_strobe = (ph == LAST);

    assert_strobe_gap_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
        mc_strobe |=> !mc_strobe);
    assert_strobe_then_instr_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        mc_strobe |=> instr_clk);
    assert_instr_single_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        instr_clk |=> !instr_clk);
endmodule

// File: rtl/sysclk_gen.sv
// System clock generator top.
// Mode register -> glitch-free source mux -> gated prescaler -> divide-by-three.
// Assumes rst_n is held low long enough for every domain to see it.
module sysclk_gen
    import sysclk_pkg::*;
(
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              clk_ring,
    input  logic              clk_high,
    input  logic              clk_low,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] rd_data,
    output logic              sys_clk,
    output logic              instr_clk,
    output logic              mc_strobe
);
    mode_t              mode;
    logic [NUM_SRC-1:0] clk_src;
    logic               mclk;

    assign clk_src = {clk_low, clk_high, clk_ring};
    assign rd_data = MODE_W'(mode);

    sysclk_mode_reg u_mode (
        .cfg_clk (cfg_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode)
    );

    sysclk_src_mux #(.N_SRC(NUM_SRC), .SYNC_STAGES(2), .RESET_SRC(0)) u_mux (
        .cfg_clk (cfg_clk),
        .rst_n   (rst_n),
        .clk_src (clk_src),
        .sel     (mode.src),
        .clk_out (mclk)
    );

    sysclk_prescaler #(.CODE_W(DIV_W), .SYNC_STAGES(2)) u_pre (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .div_code (mode.div),
        .sys_clk  (sys_clk)
    );

    sysclk_div3 #(.DIV_FACTOR(3)) u_div3 (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .instr_clk (instr_clk),
        .mc_strobe (mc_strobe)
    );
endmodule

// File: tb/sysclk_gen_test.sv
`timescale 1ns/1ps
module sysclk_gen_test;
    logic       cfg_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ring = 1'b0;
    logic       clk_high = 1'b0;
    logic       clk_low = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] rd_data;
    logic       sys_clk;
    logic       instr_clk;
    logic       mc_strobe;

    int checks = 0;
    int fails  = 0;

    // Half periods in ns: ring 15, fast 8, slow 35.
    always #10 cfg_clk  = ~cfg_clk;
    always #15 clk_ring = ~clk_ring;
    always #8  clk_high = ~clk_high;
    always #35 clk_low  = ~clk_low;

    sysclk_gen uut (
        .cfg_clk   (cfg_clk),
        .rst_n     (rst_n),
        .clk_ring  (clk_ring),
        .clk_high  (clk_high),
        .clk_low   (clk_low),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .sys_clk   (sys_clk),
        .instr_clk (instr_clk),
        .mc_strobe (mc_strobe)
    );

    typedef struct packed {
        logic [3:0] wd;
        logic [3:0] rb;
        logic [15:0] per;
    } vec_t;

    // Write value, expected readback, expected system clock period (ns).
    localparam vec_t VEC [10] = '{
        '{4'h3, 4'h3, 16'd240},   // R4 ring, R3 /8
        '{4'h2, 4'h2, 16'd120},   // R3 /4
        '{4'h1, 4'h1, 16'd60},    // R3 /2
        '{4'h0, 4'h0, 16'd30},    // R3 /1
        '{4'h7, 4'h7, 16'd128},   // R4 fast /8
        '{4'h5, 4'h5, 16'd32},    // fast /2
        '{4'h8, 4'h8, 16'd70},    // R4 slow /1
        '{4'hB, 4'hB, 16'd560},   // slow /8
        '{4'h9, 4'h9, 16'd140},   // slow /2
        '{4'h6, 4'h6, 16'd64}     // fast /4
    };

    // Edge monitor for pulse widths and periods of the system clock.
    realtime rise_t, fall_t, min_hi, min_lo, min_per;
    bit have_rise, have_fall;
    always @(posedge sys_clk) begin
        if (have_fall && ($realtime - fall_t) < min_lo) min_lo = $realtime - fall_t;
        if (have_rise && ($realtime - rise_t) < min_per) min_per = $realtime - rise_t;
        rise_t = $realtime;
        have_rise = 1'b1;
    end
    always @(negedge sys_clk) begin
        if (have_rise && ($realtime - rise_t) < min_hi) min_hi = $realtime - rise_t;
        fall_t = $realtime;
        have_fall = 1'b1;
    end

    task automatic mon_clear();
        have_rise = 1'b0;
        have_fall = 1'b0;
        min_hi  = 1.0e9;
        min_lo  = 1.0e9;
        min_per = 1.0e9;
    endtask

    task automatic chk_int(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_time(input bit ok, input string req, input realtime act, input realtime exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0t expected=%0t", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [3:0] d);
        @(negedge cfg_clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge cfg_clk);
        wr_en   = 1'b0;
    endtask

    task automatic measure(output realtime p);
        realtime t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $realtime - t0;
    endtask

    function automatic bit near(input realtime a, input realtime b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        realtime p;
        int hits;
        bit prev, twin;
        mon_clear();

        // Reset, released away from a system clock edge.
        #2000;
        @(negedge sys_clk);
        rst_n = 1'b1;
        @(posedge sys_clk);
        #1;
        chk_int(mc_strobe == 1'b0, "R9 strobe low after first edge", int'(mc_strobe), 0);
        @(posedge sys_clk);
        #1;
        chk_int(mc_strobe == 1'b1, "R9 strobe high on second edge", int'(mc_strobe), 1);
        @(negedge cfg_clk);
        chk_int(rd_data == 4'h3, "R1 reset readback", int'(rd_data), 3);
        measure(p);
        chk_time(near(p, 240.0), "R2 reset period ring/8", p, 240.0);

        // Table of mode settings.
        foreach (VEC[k]) begin
            write_mode(VEC[k].wd);
            chk_int(rd_data == VEC[k].rb, "R10 readback", int'(rd_data), int'(VEC[k].rb));
            #3000;
            measure(p);
            chk_time(near(p, realtime'(VEC[k].per)), "R3/R4 period", p, realtime'(VEC[k].per));
        end

        // R5: source code 11 keeps fast source, divide field still loads.
        write_mode(4'hC);
        chk_int(rd_data == 4'h4, "R5 readback keeps source", int'(rd_data), 4);
        #3000;
        measure(p);
        chk_time(near(p, 16.0), "R5 period fast/1", p, 16.0);

        // R6: switch sources in through mode and watch pulse widths.
        write_mode(4'h0);
        #2000;
        mon_clear();
        write_mode(4'h8);
        #2000;
        write_mode(4'h4);
        #2000;
        write_mode(4'h0);
        #2000;
        chk_time(min_hi >= 7.99, "R6 minimum high phase", min_hi, 8.0);
        chk_time(min_lo >= 7.99, "R6 minimum low phase", min_lo, 8.0);
        measure(p);
        chk_time(near(p, 30.0), "R6 period after switching back", p, 30.0);

        // R7: ratio change on the ring, both directions.
        write_mode(4'h3);
        #3000;
        mon_clear();
        write_mode(4'h0);
        #1500;
        chk_time(min_per >= 29.99, "R7 min period /8 to /1", min_per, 30.0);
        mon_clear();
        write_mode(4'h3);
        #3000;
        chk_time(min_per >= 29.99, "R7 min period /1 to /8", min_per, 30.0);
        measure(p);
        chk_time(near(p, 240.0), "R7 settled /8", p, 240.0);

        // R8: instruction clock period at ring/2.
        write_mode(4'h1);
        #3000;
        @(posedge instr_clk);
        p = $realtime;
        @(posedge instr_clk);
        p = $realtime - p;
        chk_time(near(p, 180.0), "R8 instruction clock period", p, 180.0);

        // R9: one strobe cycle in three, never two in a row.
        hits = 0;
        prev = 1'b0;
        twin = 1'b0;
        for (int n = 0; n < 30; n++) begin
            @(negedge sys_clk);
            if (mc_strobe) hits++;
            if (mc_strobe && prev) twin = 1'b1;
            prev = mc_strobe;
        end
        chk_int(hits == 10, "R9 strobe count over 30 cycles", hits, 10);
        chk_int(twin == 1'b0, "R9 no back-to-back strobes", int'(twin), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule